// File: doc/BRIEF.md
# Conversion Scan Sequencer

This block decides when a sensing front end with sixteen inputs converts and in which order its channels are taken. A start comes either from a software strobe or from one of sixteen external trigger lines chosen by a four-bit selector. The block then runs one of four modes. It can convert one channel once. It can walk once over the channels enabled in a sixteen-bit mask. It can convert one channel over and over. Or it can walk the enabled channels in a loop.

The conversion engine is outside this block. The sequencer raises a convert request with a channel number and waits for a one-cycle completion pulse. A compare-event input, sampled with that pulse, ends either continuous mode. Two sticky flags report a finished conversion and a finished pass. Each flag has its own interrupt enable, and the interrupt line combines them.

Top module: `cnv_scan_seq`

## Requirements
- R1: With `mode` = 0 (one conversion), a start converts `single_chan` once. `busy` falls in the cycle after `conv_done` is accepted.
- R2: With `mode` = 1 (one pass), the channels whose bit is 1 in `chan_mask` are converted once each, from the lowest index to the highest. `eos_flag` then sets and the block goes idle.
- R3: With `mode` = 2 (repeat one channel), `single_chan` is converted again and again. It stops when `enable` goes low, or when `cmp_event` is high together with an accepted `conv_done`.
- R4: With `mode` = 3 (looping pass), the walk wraps from the highest enabled channel back to the lowest. `eos_flag` sets at the end of every pass, and the walk stops under the same conditions as R3.
- R5: A start in mode 1 or 3 with `chan_mask` = 0 makes no conversion. `busy` stays 0 and `eos_flag` sets in the next cycle.
- R6: When `sw_sel` = 1, `sw_start` starts a run. When `sw_sel` = 0, `trig_in[trig_sel]` starts a run and the other trigger lines are ignored. No start is taken while `enable` = 0 or while `busy` = 1.
- R7: `busy` and `conv_req` are 1 from the cycle after a start until the run ends. While they are 1, `conv_chan` holds the channel being converted.
- R8: `done_flag` sets in the cycle after an accepted `conv_done`. A `done_wr` strobe loads `done_wr_val`, so 0 clears the flag and 1 forces it. A hardware set wins over a clearing write in the same cycle.
- R9: An `eos_clr` strobe clears `eos_flag`. A pass ending in the same cycle wins and leaves the flag set.
- R10: `irq` is (`done_flag` AND `done_ie`) OR (`eos_flag` AND `eos_ie`).
- R11: Clearing `enable` during a run sends the block idle in the next cycle. A `conv_done` arriving in that same cycle is dropped.
- R12: After reset, `busy`, `conv_req`, `conv_chan`, `done_flag`, `eos_flag` and `irq` are all 0.
- R13: A `conv_done` that arrives while the block is idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Module enable; when low, any run in progress is aborted |
| mode | input | 2 | Run mode: 0 one conversion, 1 one pass, 2 repeat channel, 3 looping pass |
| sw_sel | input | 1 | 1 selects the software strobe as the start source |
| sw_start | input | 1 | Software start strobe |
| trig_sel | input | 4 | Index of the external trigger line used for starts |
| trig_in | input | 16 | External trigger lines |
| chan_mask | input | 16 | Channels taken part in scan modes |
| single_chan | input | 4 | Channel converted in modes 0 and 2 |
| conv_req | output | 1 | Convert request to the engine |
| conv_chan | output | 4 | Channel to convert |
| conv_done | input | 1 | One-cycle completion pulse from the engine |
| cmp_event | input | 1 | Threshold event, sampled with `conv_done` |
| busy | output | 1 | A run is in progress |
| done_wr | input | 1 | Write strobe for the conversion-done flag |
| done_wr_val | input | 1 | Value loaded by `done_wr` |
| eos_clr | input | 1 | Clear strobe for the end-of-pass flag |
| done_ie | input | 1 | Interrupt enable for `done_flag` |
| eos_ie | input | 1 | Interrupt enable for `eos_flag` |
| done_flag | output | 1 | Sticky conversion-done flag |
| eos_flag | output | 1 | Sticky end-of-pass flag |
| irq | output | 1 | Combined interrupt |

## Verification
Two situations are hard to reach from the ports:
- A clearing write to the done flag landing in the same cycle as an accepted completion.
- A completion pulse arriving while the block is idle.

A free-running engine model never produces either of them. For these cases the bench switches off its automatic engine and drives `conv_done` by hand on chosen cycles.

Stopping a looping pass is reached differently. The bench counts completions observed at the ports and raises `cmp_event` part-way through a later pass. It then checks that the walk ends after the following conversion and that the wrap order was kept.

// File: rtl/cs_seq_pkg.sv
// Shared types for the conversion scan sequencer.
package cs_seq_pkg;
    typedef enum logic [1:0] {
        MODE_ONE    = 2'd0,
        MODE_PASS   = 2'd1,
        MODE_REPEAT = 2'd2,
        MODE_LOOP   = 2'd3
    } run_mode_e;
endpackage

// File: rtl/cs_start_pick.sv
// Start source selection.
// Produces a one-cycle start request from either the software strobe or the
// selected external trigger line. Assumes trigger lines are synchronous.
module cs_start_pick #(
    parameter int NUM_TRIG = 16,
    localparam int TSEL_W  = $clog2(NUM_TRIG)
) (
    input  logic                sw_sel,
    input  logic                sw_start,
    input  logic [TSEL_W-1:0]   trig_sel,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic                enable,
    input  logic                idle,
    output logic                start
);
    logic src_hit;

    // Pick the active source, then gate with enable and idle.
    always_comb begin
        src_hit = sw_sel ? sw_start : trig_in[trig_sel];
        start   = src_hit && enable && idle;
    end
endmodule

// File: rtl/cs_chan_find.sv
// Channel search over the enable mask.
// Gives the lowest enabled channel and the lowest enabled channel above the
// current one. Purely combinational; assumes NUM_CH is a power of two.
module cs_chan_find #(
    parameter int NUM_CH = 16,
    localparam int SEL_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [SEL_W-1:0]  cur,
    output logic              any_ok,
    output logic [SEL_W-1:0]  first_ch,
    output logic              above_ok,
    output logic [SEL_W-1:0]  above_ch
);
    // Scan from high to low so that the lowest match is the last one written.
    always_comb begin
        any_ok   = 1'b0;
        first_ch = '0;
        above_ok = 1'b0;
        above_ch = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                any_ok   = 1'b1;
                first_ch = SEL_W'(i);
                if (i > int'(cur)) begin
                    above_ok = 1'b1;
                    above_ch = SEL_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/cs_flag_bank.sv
// Sticky status flags and interrupt combine.
// A hardware set has priority over a software write in the same cycle.
module cs_flag_bank (
    input  logic clk,
    input  logic rst_n,
    input  logic done_set,
    input  logic done_wr,
    input  logic done_wr_val,
    input  logic eos_set,
    input  logic eos_clr,
    input  logic done_ie,
    input  logic eos_ie,
    output logic done_flag,
    output logic eos_flag,
    output logic irq
);
    // Conversion-done flag: set by hardware, loaded by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        done_flag <= 1'b0;
        else if (done_set) done_flag <= 1'b1;
        else if (done_wr)  done_flag <= done_wr_val;
    end

    // End-of-pass flag: set by hardware, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        eos_flag <= 1'b0;
        else if (eos_set)  eos_flag <= 1'b1;
        else if (eos_clr)  eos_flag <= 1'b0;
    end

    // Interrupt: each flag qualified by its own enable.
    always_comb irq = (done_flag && done_ie) || (eos_flag && eos_ie);

    // R10
    irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && done_ie) |-> irq);

    // R10
    irq_eos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_flag && eos_ie) |-> irq);

    // R9
    eos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos_set |=> eos_flag);
endmodule

// File: rtl/cnv_scan_seq.sv
// Conversion scan sequencer, top level.
// Runs one of four modes over a masked set of channels and handshakes each
// conversion with an external engine (request level, one-cycle done pulse).
// Assumes mode and single_chan are held while a run starts; the mode is
// latched at start and the mask is read live at each step.
module cnv_scan_seq
    import cs_seq_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int NUM_TRIG = 16,
    localparam int SEL_W   = $clog2(NUM_CH),
    localparam int TSEL_W  = $clog2(NUM_TRIG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [1:0]          mode,
    input  logic                sw_sel,
    input  logic                sw_start,
    input  logic [TSEL_W-1:0]   trig_sel,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [NUM_CH-1:0]   chan_mask,
    input  logic [SEL_W-1:0]    single_chan,
    output logic                conv_req,
    output logic [SEL_W-1:0]    conv_chan,
    input  logic                conv_done,
    input  logic                cmp_event,
    output logic                busy,
    input  logic                done_wr,
    input  logic                done_wr_val,
    input  logic                eos_clr,
    input  logic                done_ie,
    input  logic                eos_ie,
    output logic                done_flag,
    output logic                eos_flag,
    output logic                irq
);
    logic             busy_q, busy_d;
    logic [SEL_W-1:0] chan_q, chan_d;
    run_mode_e        mode_q, mode_d;
    logic             start, done_set, eos_set, stop_req;
    logic             any_ok, above_ok;
    logic [SEL_W-1:0] first_ch, above_ch;

    cs_start_pick #(.NUM_TRIG(NUM_TRIG)) i_start (
        .sw_sel(sw_sel), .sw_start(sw_start), .trig_sel(trig_sel),
        .trig_in(trig_in), .enable(enable), .idle(!busy_q), .start(start)
    );

    cs_chan_find #(.NUM_CH(NUM_CH)) i_find (
        .mask(chan_mask), .cur(chan_q), .any_ok(any_ok), .first_ch(first_ch),
        .above_ok(above_ok), .above_ch(above_ch)
    );

    cs_flag_bank i_flags (
        .clk(clk), .rst_n(rst_n), .done_set(done_set), .done_wr(done_wr),
        .done_wr_val(done_wr_val), .eos_set(eos_set), .eos_clr(eos_clr),
        .done_ie(done_ie), .eos_ie(eos_ie), .done_flag(done_flag),
        .eos_flag(eos_flag), .irq(irq)
    );

    // Next-state logic: start, abort, and advance on each completion.
    always_comb begin
        busy_d   = busy_q;
        chan_d   = chan_q;
        mode_d   = mode_q;
        done_set = 1'b0;
        eos_set  = 1'b0;
        stop_req = mode_q[1] && cmp_event;
        if (!busy_q) begin
            if (start) begin
                mode_d = run_mode_e'(mode);
                if (!mode[0]) begin
                    busy_d = 1'b1;
                    chan_d = single_chan;
                end else if (any_ok) begin
                    busy_d = 1'b1;
                    chan_d = first_ch;
                end else begin
                    eos_set = 1'b1;
                end
            end
        end else if (!enable) begin
            busy_d = 1'b0;
        end else if (conv_done) begin
            done_set = 1'b1;
            case (mode_q)
                MODE_ONE:    busy_d = 1'b0;
                MODE_REPEAT: busy_d = !stop_req;
                default: begin
                    if (above_ok) begin
                        if (stop_req) busy_d = 1'b0;
                        else          chan_d = above_ch;
                    end else begin
                        eos_set = 1'b1;
                        if (mode_q == MODE_PASS || stop_req || !any_ok)
                            busy_d = 1'b0;
                        else
                            chan_d = first_ch;
                    end
                end
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            chan_q <= '0;
            mode_q <= MODE_ONE;
        end else begin
            busy_q <= busy_d;
            chan_q <= chan_d;
            mode_q <= mode_d;
        end
    end

    // Outputs straight from state.
    always_comb begin
        busy      = busy_q;
        conv_req  = busy_q;
        conv_chan = busy_q ? chan_q : '0;
    end

    // R11
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !enable) |=> !busy_q);

    // R8
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && enable && conv_done) |=> done_flag);

    // R1
    single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && enable && conv_done && mode_q == MODE_ONE) |=> !busy_q);

    // R5
    empty_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode[0] && chan_mask == '0) |=> (!busy_q && eos_flag));

    // R13
    stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && conv_done && !done_wr) |=> (done_flag == $past(done_flag)));
endmodule

// File: tb/test_cnv_scan_seq.sv
module test_cnv_scan_seq;
    logic        clk = 0, rst_n = 0;
    logic        enable = 0, sw_sel = 1, sw_start = 0, cmp_event = 0;
    logic [1:0]  mode = 0;
    logic [3:0]  trig_sel = 0, single_chan = 0, conv_chan;
    logic [15:0] trig_in = 0, chan_mask = 0;
    logic        conv_req, conv_done = 0, busy;
    logic        done_wr = 0, done_wr_val = 0, eos_clr = 0, done_ie = 0, eos_ie = 0;
    logic        done_flag, eos_flag, irq;

    int tests = 0, fails = 0, cycles = 0, lat = 3, cnt = 0;
    bit eng_auto = 1, model_on = 0;
    int conv_log[$];

    // reference model state
    int m_busy = 0, m_chan = 0, m_mode = 0, m_done = 0, m_eos = 0;

    always #5 clk = ~clk;

    cnv_scan_seq i_cnv_scan_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .sw_sel(sw_sel),
        .sw_start(sw_start), .trig_sel(trig_sel), .trig_in(trig_in),
        .chan_mask(chan_mask), .single_chan(single_chan), .conv_req(conv_req),
        .conv_chan(conv_chan), .conv_done(conv_done), .cmp_event(cmp_event),
        .busy(busy), .done_wr(done_wr), .done_wr_val(done_wr_val),
        .eos_clr(eos_clr), .done_ie(done_ie), .eos_ie(eos_ie),
        .done_flag(done_flag), .eos_flag(eos_flag), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic int next_en(logic [15:0] m, int after);
        for (int i = after + 1; i < 16; i++) if (m[i]) return i;
        return -1;
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        int nb, nc, nd, ne;
        bit st, hd, he, stop;
        nb = m_busy; nc = m_chan; nd = m_done; ne = m_eos; hd = 0; he = 0;
        if (!rst_n) begin
            m_busy = 0; m_chan = 0; m_mode = 0; m_done = 0; m_eos = 0;
        end else begin
            st = enable && (sw_sel ? sw_start : trig_in[trig_sel]);
            if (m_busy == 0) begin
                if (st) begin
                    m_mode = mode;
                    if (mode == 0 || mode == 2) begin nb = 1; nc = single_chan; end
                    else if (next_en(chan_mask, -1) >= 0) begin nb = 1; nc = next_en(chan_mask, -1); end
                    else he = 1;
                end
            end else if (!enable) nb = 0;
            else if (conv_done) begin
                hd = 1;
                stop = (m_mode >= 2) && cmp_event;
                if (m_mode == 0) nb = 0;
                else if (m_mode == 2) begin if (stop) nb = 0; end
                else if (next_en(chan_mask, m_chan) >= 0) begin
                    if (stop) nb = 0; else nc = next_en(chan_mask, m_chan);
                end else begin
                    he = 1;
                    if (m_mode == 1 || stop || next_en(chan_mask, -1) < 0) nb = 0;
                    else nc = next_en(chan_mask, -1);
                end
            end
            if (hd) nd = 1; else if (done_wr) nd = done_wr_val;
            if (he) ne = 1; else if (eos_clr) ne = 0;
            m_busy = nb; m_chan = nc; m_done = nd; m_eos = ne;
        end
    end

    // compare every cycle away from the edge; log conversions seen at the ports
    always @(negedge clk) begin
        cycles++;
        if (model_on) begin
            chk("R7 busy", busy, m_busy);
            chk("R7 conv_req", conv_req, m_busy);
            if (m_busy) chk("R7 conv_chan", conv_chan, m_chan);
            chk("R8 done_flag", done_flag, m_done);
            chk("R9 eos_flag", eos_flag, m_eos);
            chk("R10 irq", irq, int'((m_done && done_ie) || (m_eos && eos_ie)));
        end
        if (conv_req && conv_done && enable) conv_log.push_back(conv_chan);
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // conversion engine stand-in
    always @(posedge clk) begin
        #2;
        if (eng_auto) begin
            if (conv_req && !conv_done && cnt >= lat) begin conv_done = 1; cnt = 0; end
            else begin conv_done = 0; cnt = conv_req ? cnt + 1 : 0; end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic sw_pulse();
        sw_start = 1; step(); sw_start = 0;
    endtask

    task automatic wait_idle();
        step();
        while (busy) step();
        step();
    endtask

    task automatic clear_flags();
        done_wr = 1; done_wr_val = 0; eos_clr = 1; step();
        done_wr = 0; eos_clr = 0; step();
    endtask

    initial begin
        step(3);
        @(negedge clk);
        // R12 reset state
        chk("R12 busy", busy, 0); chk("R12 conv_req", conv_req, 0);
        chk("R12 conv_chan", conv_chan, 0); chk("R12 done_flag", done_flag, 0);
        chk("R12 eos_flag", eos_flag, 0); chk("R12 irq", irq, 0);
        step(); rst_n = 1; enable = 1; model_on = 1; step();

        // R1 single conversion on channel 5
        mode = 0; single_chan = 5; conv_log.delete();
        sw_pulse(); wait_idle();
        chk("R1 count", conv_log.size(), 1);
        if (conv_log.size() > 0) chk("R1 channel", conv_log[0], 5);
        chk("R1 done_flag", done_flag, 1);

        // R8 software clear and force
        done_wr = 1; done_wr_val = 0; step(); done_wr = 0; step();
        chk("R8 cleared", done_flag, 0);
        done_wr = 1; done_wr_val = 1; step(); done_wr = 0; step();
        chk("R8 forced", done_flag, 1);
        clear_flags();

        // R2 + R6: one pass started from external trigger line 7
        sw_sel = 0; trig_sel = 7; mode = 1; chan_mask = 16'hA412; conv_log.delete();
        trig_in[7] = 1; step(); trig_in[7] = 0;
        wait_idle();
        begin
            int exp_ch[5] = '{1, 4, 10, 13, 15};
            chk("R2 count", conv_log.size(), 5);
            for (int k = 0; k < 5 && k < conv_log.size(); k++) chk("R2 order", conv_log[k], exp_ch[k]);
        end
        chk("R2 eos_flag", eos_flag, 1);

        // R10 interrupt enables
        eos_ie = 1; step(); @(negedge clk); chk("R10 irq on", irq, 1);
        eos_ie = 0; step(); @(negedge clk); chk("R10 irq off", irq, 0);

        // R9 clear end-of-pass
        eos_clr = 1; step(); eos_clr = 0; step();
        chk("R9 eos cleared", eos_flag, 0);

        // R6 unselected trigger and disabled module are ignored
        trig_in[3] = 1; step(); trig_in[3] = 0; step(2);
        chk("R6 other trigger ignored", busy, 0);
        enable = 0; trig_in[7] = 1; step(); trig_in[7] = 0; step(2);
        chk("R6 disabled ignored", busy, 0);
        enable = 1; sw_sel = 1; step();

        // R5 empty mask scan
        chan_mask = 0; conv_log.delete(); sw_pulse(); step();
        chk("R5 busy", busy, 0); chk("R5 eos_flag", eos_flag, 1);
        chk("R5 no conversion", conv_log.size(), 0);
        clear_flags();

        // R4 looping pass over channels 0 and 15, stopped by compare event
        mode = 3; chan_mask = 16'h8001; conv_log.delete(); sw_pulse();
        while (conv_log.size() < 4) step();
        cmp_event = 1; wait_idle(); cmp_event = 0;
        chk("R4 stopped", busy, 0);
        chk("R4 count", int'(conv_log.size() >= 5), 1);
        for (int k = 0; k < conv_log.size(); k++) chk("R4 wrap order", conv_log[k], (k % 2) ? 15 : 0);
        chk("R4 eos_flag", eos_flag, 1);
        clear_flags();

        // R3 + R11 repeat channel 9, aborted by enable
        mode = 2; single_chan = 9; conv_log.delete(); sw_pulse();
        while (conv_log.size() < 3) step();
        enable = 0; step(); @(negedge clk);
        chk("R11 aborted", busy, 0);
        for (int k = 0; k < conv_log.size(); k++) chk("R3 channel", conv_log[k], 9);
        enable = 1; clear_flags();

        // R3 compare event ends repeat after one conversion
        cmp_event = 1; conv_log.delete(); sw_pulse(); wait_idle(); cmp_event = 0;
        chk("R3 cmp stop count", conv_log.size(), 1);
        clear_flags();

        // R13 stray completion while idle
        eng_auto = 0; conv_done = 1; step(); conv_done = 0; step();
        chk("R13 done unchanged", done_flag, 0);
        chk("R13 still idle", busy, 0);

        // R8 hardware set wins over a clearing write
        mode = 0; single_chan = 2; sw_pulse(); step();
        conv_done = 1; done_wr = 1; done_wr_val = 0; step();
        conv_done = 0; done_wr = 0; step();
        chk("R8 set priority", done_flag, 1);
        chk("R1 idle after done", busy, 0);
        eng_auto = 1; step(3);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule